// File: doc/BRIEF.md
# Next-PC and Link Computation Unit

This unit sits next to the fetch stage of a 32-bit load/store processor. Each cycle it takes the current program counter, the fetched instruction word, one register operand (already read by the caller from the register named in the rs1 field) and the single-bit floating-point condition flag. From these it works out where fetch goes next. It also says whether the flow was redirected, and whether register 31 must take a return address, with that address.

All relative targets are offsets from the delay-slot address (PC+4). Branches carry a signed 16-bit offset and relative jumps carry a signed 26-bit offset. The return address skips the delay slot, so it is PC+8. Trap and return-from-exception are recognised: a trap goes to an unsigned absolute address taken from the instruction, and a return-from-exception goes to the operand value, which the caller supplies from the saved return address. All results are registered and appear one clock after the inputs are sampled.

The opcode is the top six bits of the instruction word, instr_i[31:26]. The branch offset is instr_i[15:0] and the jump field is instr_i[25:0].

Top module: `nxpc_unit`

## Requirements
- R1: While rst_ni is low, next_pc_o, taken_o, link_we_o and link_val_o are all zero, whatever the inputs are.
- R2: Each output reflects the inputs sampled at the previous rising clock edge. Changing the inputs between edges does not change the outputs.
- R3: Any opcode outside the set listed in R4 to R11 gives next_pc_o = pc_i+4 (modulo 2^32), with taken_o=0 and link_we_o=0.
- R4: Opcode 0x04 (branch if zero) is taken when opnd_i equals 0. In that case next_pc_o = pc_i+4+sign-extended instr_i[15:0]. Otherwise next_pc_o = pc_i+4. taken_o follows the condition.
- R5: Opcode 0x05 (branch if non-zero) is taken when opnd_i is not 0. It uses the same target and fall-through as R4.
- R6: Opcode 0x06 branches when fp_flag_i=1 and opcode 0x07 branches when fp_flag_i=0. Both use the R4 target and fall-through.
- R7: Opcodes 0x02 (jump) and 0x03 (jump and link) are always taken, to pc_i+4+sign-extended instr_i[25:0].
- R8: Opcodes 0x12 (jump register) and 0x13 (jump register and link) are always taken, to the full unsigned opnd_i.
- R9: Only opcodes 0x03 and 0x13 set link_we_o=1, and they set link_val_o = pc_i+8. In every other case link_we_o=0 and link_val_o=0.
- R10: Opcode 0x11 (trap) is taken to the zero-extended instr_i[25:0] and writes no link.
- R11: Opcode 0x10 (return from exception) is taken to opnd_i and writes no link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Fetched instruction word |
| opnd_i | input | 32 | Value of the register named by the rs1 field |
| fp_flag_i | input | 1 | Floating-point condition flag |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Flow redirected away from PC+4 |
| link_we_o | output | 1 | Write request for register 31 |
| link_val_o | output | 32 | Return address for register 31 |

## Verification
Every result (target, taken flag, link request and link value) is due exactly one rising edge after its inputs are driven. The bench therefore drives a vector shortly after an edge, computes the expected outputs from its own model of the requirements, and compares them a short delay after the next edge. One check changes the inputs between edges and confirms that the outputs keep their previous values until the edge. This shows that no path runs straight from input to output.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  localparam int unsigned ILEN = 32;
  localparam int unsigned OPW  = 6;
  localparam int unsigned BOFW = 16;
  localparam int unsigned JOFW = 26;

  localparam logic [OPW-1:0] OP_J    = 6'h02;
  localparam logic [OPW-1:0] OP_JAL  = 6'h03;
  localparam logic [OPW-1:0] OP_BZ   = 6'h04;
  localparam logic [OPW-1:0] OP_BNZ  = 6'h05;
  localparam logic [OPW-1:0] OP_BFT  = 6'h06;
  localparam logic [OPW-1:0] OP_BFF  = 6'h07;
  localparam logic [OPW-1:0] OP_RFE  = 6'h10;
  localparam logic [OPW-1:0] OP_TRAP = 6'h11;
  localparam logic [OPW-1:0] OP_JR   = 6'h12;
  localparam logic [OPW-1:0] OP_JALR = 6'h13;

  typedef enum logic [2:0] {K_SEQ, K_BR, K_JREL, K_JREG, K_TRAP} kind_e;
  typedef enum logic [1:0] {C_ZERO, C_NZERO, C_FPT, C_FPF} cond_e;

  typedef struct packed {
    kind_e kind;
    cond_e cond;
    logic  link;
  } ctrl_t;
endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
  import nxpc_pkg::*;
(
  input  logic [OPW-1:0] opcode_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = '{kind: K_SEQ, cond: C_ZERO, link: 1'b0};
    unique case (opcode_i)
      OP_J:    ctrl_o.kind = K_JREL;
      OP_JAL:  begin ctrl_o.kind = K_JREL; ctrl_o.link = 1'b1; end
      OP_BZ:   begin ctrl_o.kind = K_BR; ctrl_o.cond = C_ZERO;  end
      OP_BNZ:  begin ctrl_o.kind = K_BR; ctrl_o.cond = C_NZERO; end
      OP_BFT:  begin ctrl_o.kind = K_BR; ctrl_o.cond = C_FPT;   end
      OP_BFF:  begin ctrl_o.kind = K_BR; ctrl_o.cond = C_FPF;   end
      OP_RFE:  ctrl_o.kind = K_JREG;
      OP_TRAP: ctrl_o.kind = K_TRAP;
      OP_JR:   ctrl_o.kind = K_JREG;
      OP_JALR: begin ctrl_o.kind = K_JREG; ctrl_o.link = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/nxpc_cond.sv
module nxpc_cond
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cond_e           cond_i,
  input  logic [XLEN-1:0] opnd_i,
  input  logic            fp_flag_i,
  output logic            hit_o
);
  logic is_zero;
  assign is_zero = (opnd_i == '0);

  always_comb begin
    unique case (cond_i)
      C_ZERO:  hit_o = is_zero;
      C_NZERO: hit_o = !is_zero;
      C_FPT:   hit_o = fp_flag_i;
      C_FPF:   hit_o = !fp_flag_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [JOFW-1:0] field_i,
  output logic [XLEN-1:0] seq_o,
  output logic [XLEN-1:0] br_o,
  output logic [XLEN-1:0] jrel_o,
  output logic [XLEN-1:0] trap_o,
  output logic [XLEN-1:0] link_o
);
  localparam int unsigned BEXT = XLEN - BOFW;
  localparam int unsigned JEXT = XLEN - JOFW;
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic [XLEN-1:0] boff, joff;

  assign boff   = {{BEXT{field_i[BOFW-1]}}, field_i[BOFW-1:0]};
  assign joff   = {{JEXT{field_i[JOFW-1]}}, field_i};
  assign seq_o  = pc_i + STEP;
  assign br_o   = seq_o + boff;
  assign jrel_o = seq_o + joff;
  assign trap_o = {{JEXT{1'b0}}, field_i};
  assign link_o = seq_o + STEP;  // skip the delay slot
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] pc_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] opnd_i,
  input  logic            fp_flag_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_val_o
);
  ctrl_t           ctrl;
  logic            hit;
  logic [XLEN-1:0] seq_pc, br_pc, jrel_pc, trap_pc, link_pc;
  logic [XLEN-1:0] nxt_d, lval_d;
  logic            tk_d;

  nxpc_decode u_dec (
    .opcode_i (instr_i[ILEN-1 -: OPW]),
    .ctrl_o   (ctrl)
  );

  nxpc_cond #(.XLEN(XLEN)) u_cond (
    .cond_i    (ctrl.cond),
    .opnd_i    (opnd_i),
    .fp_flag_i (fp_flag_i),
    .hit_o     (hit)
  );

  nxpc_target #(.XLEN(XLEN)) u_tgt (
    .pc_i    (pc_i),
    .field_i (instr_i[JOFW-1:0]),
    .seq_o   (seq_pc),
    .br_o    (br_pc),
    .jrel_o  (jrel_pc),
    .trap_o  (trap_pc),
    .link_o  (link_pc)
  );

  always_comb begin
    tk_d  = 1'b1;
    nxt_d = seq_pc;
    unique case (ctrl.kind)
      K_BR:    begin tk_d = hit; nxt_d = hit ? br_pc : seq_pc; end
      K_JREL:  nxt_d = jrel_pc;
      K_JREG:  nxt_d = opnd_i;
      K_TRAP:  nxt_d = trap_pc;
      default: tk_d = 1'b0;
    endcase
    lval_d = ctrl.link ? link_pc : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o  <= '0;
      taken_o    <= 1'b0;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
    end else begin
      next_pc_o  <= nxt_d;
      taken_o    <= tk_d;
      link_we_o  <= ctrl.link;
      link_val_o <= lval_d;
    end
  end

  // marks that the output registers hold a post-reset result
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  a_r3_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && !taken_o |-> next_pc_o == $past(pc_i) + XLEN'(4));

  a_r9_link_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && link_we_o |-> taken_o && link_val_o == $past(pc_i) + XLEN'(8));

  a_r9_link_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_we_o |-> link_val_o == '0);

  a_r8_reg_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && ($past(instr_i[ILEN-1 -: OPW]) == OP_JR ||
               $past(instr_i[ILEN-1 -: OPW]) == OP_JALR)
    |-> taken_o && next_pc_o == $past(opnd_i));

  a_r10_trap_abs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(instr_i[ILEN-1 -: OPW]) == OP_TRAP
    |-> taken_o && !link_we_o && next_pc_o[XLEN-1:JOFW] == '0);
endmodule

// File: tb/nxpc_unit_bench.sv
module nxpc_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = 32'h1234_5678;
  logic [31:0] instr_i = 32'h0C00_0010;
  logic [31:0] opnd_i = 32'hDEAD_BEEF;
  logic        fp_flag_i = 1'b1;
  logic [31:0] next_pc_o, link_val_o;
  logic        taken_o, link_we_o;

  int errors = 0;
  int checks = 0;

  nxpc_unit u_nxpc_unit (
    .clk_i, .rst_ni, .pc_i, .instr_i, .opnd_i, .fp_flag_i,
    .next_pc_o, .taken_o, .link_we_o, .link_val_o
  );

  always #5 clk_i = ~clk_i;

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] mk_b(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd3, 5'd0, imm};
  endfunction

  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] f);
    return {op, f};
  endfunction

  // behavioural reference from the requirements
  function automatic void model(input logic [31:0] pc, ins, op, input logic fp,
                                output logic [31:0] npc, output logic tk,
                                output logic lw, output logic [31:0] lv);
    int code;
    logic [31:0] fall, btgt, jtgt;
    bit cnd;
    code = int'(ins[31:26]);
    fall = pc + 32'd4;
    btgt = fall + {{16{ins[15]}}, ins[15:0]};
    jtgt = fall + {{6{ins[25]}}, ins[25:0]};
    npc = fall; tk = 1'b0; lw = 1'b0; lv = 32'd0;
    cnd = 0;
    case (code)
      2, 3: begin npc = jtgt; tk = 1'b1; lw = (code == 3); end
      4, 5, 6, 7: begin
        if (code == 4) cnd = (op == 0);
        else if (code == 5) cnd = (op != 0);
        else if (code == 6) cnd = fp;
        else cnd = !fp;
        tk = cnd;
        npc = cnd ? btgt : fall;
      end
      16: begin npc = op; tk = 1'b1; end
      17: begin npc = {6'd0, ins[25:0]}; tk = 1'b1; end
      18, 19: begin npc = op; tk = 1'b1; lw = (code == 19); end
      default: ;
    endcase
    if (lw) lv = pc + 32'd8;
  endfunction

  function automatic string tag_of(input logic [31:0] ins);
    case (int'(ins[31:26]))
      2, 3:   return "R7";
      4:      return "R4";
      5:      return "R5";
      6, 7:   return "R6";
      16:     return "R11";
      17:     return "R10";
      18, 19: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk32(input string tag, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] e_npc, e_lv;
  logic        e_tk, e_lw;

  // drive just after an edge, compare just after the next edge
  task automatic step(input logic [31:0] pc, ins, op, input logic fp);
    string t;
    pc_i = pc; instr_i = ins; opnd_i = op; fp_flag_i = fp;
    model(pc, ins, op, fp, e_npc, e_tk, e_lw, e_lv);
    t = tag_of(ins);
    @(posedge clk_i); #2;
    chk32(t, "next_pc", next_pc_o, e_npc);
    chk32(t, "taken", {31'd0, taken_o}, {31'd0, e_tk});
    chk32("R9", "link_we", {31'd0, link_we_o}, {31'd0, e_lw});
    chk32("R9", "link_val", link_val_o, e_lv);
  endtask

  initial begin
    // R1: reset holds outputs at zero under busy inputs
    #23;
    chk32("R1", "next_pc", next_pc_o, 32'd0);
    chk32("R1", "taken", {31'd0, taken_o}, 32'd0);
    chk32("R1", "link_we", {31'd0, link_we_o}, 32'd0);
    chk32("R1", "link_val", link_val_o, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2;

    step(32'h0000_1000, 32'h8000_0000, 32'd5, 1'b0);            // R3 non-control
    step(32'hFFFF_FFFC, 32'hFC00_0000, 32'd0, 1'b0);            // R3 wrap
    step(32'h0000_2000, mk_b(6'h04, 16'h0010), 32'd0, 1'b0);    // R4 taken fwd
    step(32'h0000_2000, mk_b(6'h04, 16'hFFF0), 32'd0, 1'b0);    // R4 taken back
    step(32'h0000_2000, mk_b(6'h04, 16'h0010), 32'd1, 1'b0);    // R4 not taken
    step(32'h0000_3000, mk_b(6'h05, 16'h0020), 32'h8000_0000, 1'b0); // R5 taken
    step(32'h0000_3000, mk_b(6'h05, 16'h0020), 32'd0, 1'b1);    // R5 not taken
    step(32'h0000_4000, mk_b(6'h06, 16'h0040), 32'd0, 1'b1);    // R6 fp true taken
    step(32'h0000_4000, mk_b(6'h06, 16'h0040), 32'd0, 1'b0);    // R6 not taken
    step(32'h0000_4000, mk_b(6'h07, 16'h0040), 32'd7, 1'b0);    // R6 fp false taken
    step(32'h0000_4000, mk_b(6'h07, 16'h0040), 32'd7, 1'b1);    // R6 not taken
    step(32'h0010_0000, mk_j(6'h02, 26'h000_0100), 32'd0, 1'b0); // R7 fwd
    step(32'h0010_0000, mk_j(6'h02, 26'h3FF_FF00), 32'd0, 1'b0); // R7 back
    step(32'h0010_0000, mk_j(6'h03, 26'h000_0040), 32'd0, 1'b0); // R7 + R9 link
    step(32'h0000_5000, mk_b(6'h12, 16'h1234), 32'hCAFE_F00C, 1'b0); // R8
    step(32'h0000_5000, mk_b(6'h13, 16'h0000), 32'hFFFF_FFF0, 1'b0); // R8 + R9
    step(32'h0000_6000, mk_j(6'h11, 26'h3FF_FFFC), 32'd9, 1'b0); // R10 no sign ext
    step(32'h0000_7000, mk_j(6'h10, 26'h000_0000), 32'h0000_ABC0, 1'b0); // R11

    // R2: mid-cycle input change leaves outputs alone until the edge
    pc_i = 32'h0000_9000; instr_i = mk_j(6'h02, 26'h000_0800);
    #2;
    chk32("R2", "next_pc held", next_pc_o, 32'h0000_ABC0);
    chk32("R2", "taken held", {31'd0, taken_o}, 32'd1);
    step(32'h0000_9000, mk_j(6'h02, 26'h000_0800), 32'd0, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] ops [11];
      logic [31:0] ins, op;
      ops = '{6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
              6'h10, 6'h11, 6'h12, 6'h13, 6'h2A};
      ins = $urandom();
      ins[31:26] = ops[$urandom_range(0, 10)];
      op = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom();
      step({$urandom()} & 32'hFFFF_FFFC, ins, op, 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule